// File: doc/BRIEF.md
# MDIO Management Register Master

This block lets a host reach the management registers of an Ethernet PHY through two 16-bit registers. The first register holds the command. The second register holds the data. The host sets a go/busy bit in the command register, and the block then runs one clause-22 management frame on the MDC/MDIO pins. A separate direction bit in the same register makes that frame a write or a read.

The busy bit reads back as 1 for the whole frame and clears by itself when the frame ends. The host polls it to detect completion. For a write, the host must load the data register before it issues the command. After a read, the data register holds the 16 bits returned by the PHY. A 4-bit clock-range code in the command register sets how fast MDC runs relative to the system clock.

Top module: `mdio_reg_master`

## Requirements
- R1: After reset, both registers read 0, MDC is low and the MDIO output enable is low.
- R2: A command write with bit 0 (busy) set, issued while idle, starts a frame. Busy reads 1 from the next cycle until the frame ends.
- R3: Busy clears by itself after the 64th MDC bit. While busy is clear, MDC stays low and the MDIO output enable stays low.
- R4: Command layout is bit 0 busy, bit 1 write, bits 5:2 clock range, bits 10:6 register address and bits 15:11 PHY address.
- R5: A write frame (write bit 1) puts these 64 bits on MDIO, MSB first: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data-register bits. The output enable is high for all 64 bits.
- R6: A read frame (write bit 0) uses opcode 10. The output enable is high for the first 46 bits and low from the first turnaround bit to the end of the frame.
- R7: In a read, MDIO is sampled on each rising MDC edge of the last 16 bits. The result is stored MSB first in the data register when the frame ends.
- R8: MDC changes each value MDIO is driven to while MDC is low. The MDC period is 2*(code+1) system clocks for clock-range code `code`.
- R9: A command write while busy is set is ignored. The command register and the running frame do not change.
- R10: A data write while busy is set is ignored. While idle, a data write loads the register.
- R11: A command write with bit 0 clear, issued while idle, updates the fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 16 | Command register write value |
| data_we_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 16 | Data register write value |
| cmd_rdata_o | output | 16 | Command register readback |
| data_rdata_o | output | 16 | Data register readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Some behaviours are checked by assertions on every cycle:
- MDC and the output enable stay quiet while idle.
- The command and data registers stay frozen for the whole frame.
- A frame starts only on an accepted go command.
- The divider count stays within its half-period.

Other behaviours only the bench scenarios can show. The bench acts as the PHY and shows:
- the exact 64-bit serial image of each frame;
- where the output enable drops in a read;
- the captured read value;
- the MDC period for each clock-range code;
- that writes during a frame are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int RNG_W      = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [RNG_W-1:0]  rng;
    logic              wr;
    logic              busy;
  } cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int RNG_W    = 4,
  parameter int DIV_UNIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [RNG_W-1:0] rng_i,
  output logic             tick_o
);
  localparam int MAX_HALF = (2**RNG_W) * DIV_UNIT;
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;

  assign half   = CNT_W'((32'(rng_i) + 1) * DIV_UNIT);
  assign tick_o = run_i && (cnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half)); // R8
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic                  run_q, mdc_q, wr_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      bit_q;
  logic [DATA_W-1:0]     rd_q;
  logic [FRAME_BITS-1:0] frame;

  assign frame = {32'hFFFF_FFFF, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, reg_i, 2'b10,
                  (wr_i ? wdata_i : {DATA_W{1'b0}})};

  assign done_o    = run_q && tick_i && mdc_q && (bit_q == IDX_W'(FRAME_BITS - 1));
  assign run_o     = run_q;
  assign mdc_o     = mdc_q;
  assign mdio_o    = run_q & sh_q[FRAME_BITS-1];
  assign mdio_oe_o = run_q && (wr_q || (bit_q < IDX_W'(TA_BIT)));
  assign rdata_o   = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      mdc_q <= 1'b0;
      wr_q  <= 1'b0;
      sh_q  <= '0;
      bit_q <= '0;
      rd_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      mdc_q <= 1'b0;
      wr_q  <= wr_i;
      sh_q  <= frame;
      bit_q <= '0;
    end else if (run_q && tick_i) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        // sample on rising MDC
        if (!wr_q && bit_q >= IDX_W'(DATA_BIT)) rd_q <= {rd_q[DATA_W-2:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (done_o) run_q <= 1'b0;
        else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q); // R9
endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdio_pkg::*;
#(
  parameter int DIV_UNIT = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [15:0] cmd_wdata_i,
  input  logic        data_we_i,
  input  logic [15:0] data_wdata_i,
  output logic [15:0] cmd_rdata_o,
  output logic [15:0] data_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  cmd_t              cmd_q, cmd_in;
  logic [DATA_W-1:0] data_q;
  logic              start, tick, done, run;
  logic [DATA_W-1:0] rdata;

  assign cmd_in       = cmd_t'(cmd_wdata_i);
  assign start        = cmd_we_i && !cmd_q.busy && cmd_in.busy;
  assign cmd_rdata_o  = cmd_q;
  assign data_rdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_we_i && !cmd_q.busy) cmd_q <= cmd_in;
      else if (done)               cmd_q.busy <= 1'b0;
      if (done && !cmd_q.wr)           data_q <= rdata;
      else if (data_we_i && !cmd_q.busy) data_q <= data_wdata_i;
    end
  end

  mdio_clk_div #(.RNG_W(RNG_W), .DIV_UNIT(DIV_UNIT)) div_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .rng_i (cmd_q.rng),
    .tick_o(tick)
  );

  mdio_frame_eng eng_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .wr_i     (cmd_in.wr),
    .phy_i    (cmd_in.phy),
    .reg_i    (cmd_in.regad),
    .wdata_i  (data_q),
    .tick_i   (tick),
    .mdio_i   (mdio_i),
    .run_o    (run),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .done_o   (done),
    .rdata_o  (rdata)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_q.busy |-> (!mdc_o && !mdio_oe_o)); // R3
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_q.busy) |-> $past(cmd_we_i && cmd_wdata_i[0])); // R2
  AST_CMD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q.busy && !done) |=> $stable(cmd_q)); // R9
  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q.busy && !done) |=> $stable(data_q)); // R10
endmodule

// File: tb/mdio_reg_master_tb.sv
module mdio_reg_master_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_we = 0, data_we = 0, mdio_in = 1'b1;
  logic [15:0] cmd_wd = '0, data_wd = '0, cmd_rd, data_rd;
  logic        mdc, mdio_out, mdio_oe;
  int          tests = 0, fails = 0;
  int          cyc = 0, rises = 0, t1 = 0, t2 = 0;
  logic [63:0] cap_o = '0, cap_oe = '0, resp = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_reg_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .data_we_i(data_we), .data_wdata_i(data_wd), .cmd_rdata_o(cmd_rd),
    .data_rdata_o(data_rd), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in));

  // PHY model: capture on rising MDC, present next read bit afterwards
  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_out};
    cap_oe = {cap_oe[62:0], mdio_oe};
    if (rises == 0) t1 = cyc;
    if (rises == 1) t2 = cyc;
    if (rises < 63) mdio_in = resp[62-rises];
    rises++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [15:0] v);
    @(negedge clk); cmd_we = 1; cmd_wd = v;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic wr_data(input logic [15:0] v);
    @(negedge clk); data_we = 1; data_wd = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic arm(input logic [63:0] r);
    resp = r; rises = 0; cap_o = '0; cap_oe = '0; mdio_in = r[63];
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!cmd_rd[0]) begin ok = 1; break; end
    end
  endtask

  // {wr, phy, reg, rng, data}
  localparam logic [30:0] VEC [0:5] = '{
    {1'b1, 5'h01, 5'h00, 4'd0,  16'h1234},
    {1'b0, 5'h1F, 5'h1F, 4'd0,  16'hA5C3},
    {1'b1, 5'h15, 5'h0A, 4'd3,  16'hFFFF},
    {1'b0, 5'h00, 5'h01, 4'd2,  16'h0001},
    {1'b1, 5'h0A, 5'h15, 4'd15, 16'h8000},
    {1'b0, 5'h12, 5'h09, 4'd1,  16'h7E81}
  };

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk(cmd_rd == 0 && data_rd == 0 && !mdc && !mdio_oe, "R1", {cmd_rd, data_rd}, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 6; k++) begin
      logic wr; logic [4:0] phy, rg; logic [3:0] rng; logic [15:0] d;
      logic [63:0] exp_f, exp_oe; logic [15:0] prev;
      {wr, phy, rg, rng, d} = VEC[k];
      if (wr) wr_data(d);
      prev = data_rd;
      arm(wr ? 64'h0 : {48'hFFFF_FFFF_FFFF, d});
      wr_cmd({phy, rg, rng, wr, 1'b1});
      chk(cmd_rd[0] == 1'b1, "R2", cmd_rd, 1);
      wait_idle(ok);
      chk(ok, "R3", ok, 1);
      chk(cmd_rd == {phy, rg, rng, wr, 1'b0}, "R4", cmd_rd, {phy, rg, rng, wr, 1'b0});
      chk(rises == 64, "R3", rises, 64);
      chk((t2 - t1) == 2 * (rng + 1), "R8", t2 - t1, 2 * (rng + 1));
      if (wr) begin
        exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
        chk(cap_o == exp_f, "R5", cap_o, exp_f);
        chk(cap_oe == '1, "R5", cap_oe, '1);
        chk(data_rd == prev, "R5", data_rd, prev);
      end else begin
        exp_f  = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 18'h0};
        exp_oe = {46'h3FFF_FFFF_FFFF, 18'h0};
        chk(cap_o[63:18] == exp_f[63:18], "R6", cap_o, exp_f);
        chk(cap_oe == exp_oe, "R6", cap_oe, exp_oe);
        chk(data_rd == d, "R7", data_rd, d);
      end
      chk(!mdc && !mdio_oe, "R3", {mdc, mdio_oe}, 0);
    end

    // R11: fields update without a frame
    arm(64'h0);
    wr_cmd({5'h03, 5'h04, 4'd5, 1'b1, 1'b0});
    repeat (20) @(negedge clk);
    chk(cmd_rd == {5'h03, 5'h04, 4'd5, 1'b1, 1'b0} && rises == 0, "R11", {cmd_rd, 16'(rises)}, 0);

    // R9/R10: writes during a slow read are dropped
    arm({48'hFFFF_FFFF_FFFF, 16'hBEEF});
    wr_cmd({5'h05, 5'h06, 4'd15, 1'b0, 1'b1});
    repeat (100) @(negedge clk);
    wr_cmd({5'h1E, 5'h1D, 4'd0, 1'b1, 1'b1});
    chk(cmd_rd == {5'h05, 5'h06, 4'd15, 1'b0, 1'b1}, "R9", cmd_rd, {5'h05, 5'h06, 4'd15, 1'b0, 1'b1});
    wr_data(16'h1111);
    chk(data_rd == 16'h7E81, "R10", data_rd, 16'h7E81);
    wait_idle(ok);
    chk(ok && data_rd == 16'hBEEF, "R7", data_rd, 16'hBEEF);
    chk(cap_o[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h05, 5'h06}, "R9", cap_o, 0);
    wr_data(16'h2222);
    chk(data_rd == 16'h2222, "R10", data_rd, 16'h2222);

    // R1: reset mid-frame returns to quiet state
    arm(64'h0);
    wr_cmd({5'h01, 5'h02, 4'd2, 1'b1, 1'b1});
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cmd_rd == 0 && data_rd == 0 && !mdc && !mdio_oe, "R1", {cmd_rd, data_rd}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule